// File: doc/BRIEF.md
# FIFO Occupancy Readback and Trigger-Level Register

This block is the host-side register slice of a serial port whose transmit and receive queues each hold up to 128 characters. It keeps the programmable trigger level for each direction and lets software read how many characters sit in either queue. Software reads the counts in one of two ways. The first is a trigger/count register that is reachable only behind a line-control unlock value. The second is a general-purpose scratch byte that can be switched into a count window.

In the count window, software uses a small mode register to pick which queue the scratch read reports. In alternating mode, successive scratch reads report receive, then transmit, then receive, and so on. The most significant bit of the trigger/count register then tells software which direction the previous scratch read showed.

A read is a level strobe on `host_rd`. The addressed value is captured in the cycle the strobe rises and is held on `host_rdata` until the next strobe rises. The alternation advances when the strobe falls.

Top module: `fcnt_regblk`

## Requirements
- R1: After reset both trigger levels are 1, `host_rdata` is 0, the control bits and mode bits are 0, and the scratch byte reads 0.
- R2: Offsets 0 (trigger/count) and 1 (queue control) respond only while `lcr_val` equals 0xBF. At any other value, writes to those offsets change nothing, and reads of any offset other than 7 return 0.
- R3: A write at offset 0 sets the transmit trigger when control bit 7 is 1, and the receive trigger when it is 0. Values above 128 are stored as 128.
- R4: A read at offset 0 returns the occupancy of the queue picked by control bit 7 (1 = transmit, 0 = receive), zero-extended, across the full range 0 to 128.
- R5: While control bit 6 is 0, offset 7 is a plain read/write scratch byte, whatever the value of `lcr_val`.
- R6: While control bit 6 is 1, a read at offset 7 returns a queue count, chosen by mode bit 0 (0 = receive, 1 = transmit), whatever the value of `lcr_val`. While `lcr_val` is 0xBF, writes at offset 7 load the mode register (bits 1:0), and the stored scratch byte keeps its value.
- R7: When control bit 6 is 1 and mode bits 1:0 are 11, reads at offset 7 alternate between the receive and transmit counts. The first read shows receive, and the source flips when each read strobe falls.
- R8: Leaving alternating mode and entering it again restarts the sequence on receive.
- R9: In alternating mode, bit 7 of an offset-0 read shows the direction of the last scratch count read (0 = receive, 1 = transmit; 0 before any such read). Bits 6:0 show the low bits of the selected count.
- R10: Read data is sampled in the cycle `host_rd` rises and stays unchanged until the next rising strobe, even if the queue counts change in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, held high for the read |
| host_wdata | input | 8 | Write data |
| lcr_val | input | 8 | Current line-control register value |
| tx_count | input | CW (8) | Transmit queue occupancy |
| rx_count | input | CW (8) | Receive queue occupancy |
| host_rdata | output | 8 | Read data captured at strobe start |
| tx_trig | output | CW (8) | Transmit trigger level |
| rx_trig | output | CW (8) | Receive trigger level |

## Verification
Two functions can land in the same cycle: capturing a count at the rising edge of the read strobe, and the queue logic updating that count. The bench provokes this in two ways. In the first, it changes the receive count in the same cycle the strobe rises. In the second, it changes the count again while the strobe is still held. The judgement is that the byte returned holds the value present at the rising edge and no later value. A second read then shows the new count. A similar overlap occurs between the falling edge of a scratch read and the following offset-0 read in alternating mode. There, the bench checks that bit 7 names the direction just shown, not the one that comes next.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_TRG = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_FCR = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_SPR = 3'd7;

  localparam logic [DATA_W-1:0] UNLOCK_CODE = 8'hBF;

  // Queue control and enhanced mode bits kept by the block
  typedef struct packed {
    logic       dir_tx;    // 1: offset 0 addresses transmit side
    logic       cnt_swap;  // 1: scratch offset reads a count
    logic [1:0] emode;     // [0] count source, [1] alternate enable
  } ctl_t;
endpackage

// File: rtl/fcnt_cfg.sv
module fcnt_cfg
  import fcnt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlocked,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] scratch_o,
  output logic [CW-1:0]     tx_trig_o,
  output logic [CW-1:0]     rx_trig_o
);
  localparam int MW = (CW > DATA_W) ? CW : DATA_W;

  ctl_t              ctl_q, ctl_d;
  logic [DATA_W-1:0] spr_q, spr_d;
  logic [CW-1:0]     txt_q, txt_d, rxt_q, rxt_d;
  logic [MW-1:0]     wd_ext;
  logic [CW-1:0]     lvl;

  // Saturate programmed level at the queue depth
  always_comb begin
    wd_ext = MW'(wdata);
    lvl    = (wd_ext > MW'(DEPTH)) ? CW'(DEPTH) : wd_ext[CW-1:0];
  end

  always_comb begin
    ctl_d = ctl_q;
    spr_d = spr_q;
    txt_d = txt_q;
    rxt_d = rxt_q;
    if (unlocked && addr == OFS_FCR) begin
      ctl_d.dir_tx   = wdata[7];
      ctl_d.cnt_swap = wdata[6];
    end
    if (unlocked && addr == OFS_TRG) begin
      if (ctl_q.dir_tx) txt_d = lvl;
      else              rxt_d = lvl;
    end
    if (addr == OFS_SPR) begin
      if (unlocked && ctl_q.cnt_swap) ctl_d.emode = wdata[1:0];
      else                            spr_d       = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      spr_q <= '0;
      txt_q <= CW'(1);
      rxt_q <= CW'(1);
    end else if (wr) begin
      ctl_q <= ctl_d;
      spr_q <= spr_d;
      txt_q <= txt_d;
      rxt_q <= rxt_d;
    end
  end

  assign ctl_o     = ctl_q;
  assign scratch_o = spr_q;
  assign tx_trig_o = txt_q;
  assign rx_trig_o = rxt_q;
endmodule

// File: rtl/fcnt_alt.sv
module fcnt_alt (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_on,
  input  logic rd_start,
  input  logic rd_end,
  input  logic spr_hit,
  output logic nxt_src,
  output logic last_src
);
  logic nxt_q, nxt_d, last_q, last_d, pend_q, pend_d;
  logic upd_en;

  assign upd_en = rd_start | rd_end | ~alt_on;

  always_comb begin
    pend_d = pend_q;
    nxt_d  = nxt_q;
    last_d = last_q;
    if (rd_start)    pend_d = alt_on & spr_hit;
    else if (rd_end) pend_d = 1'b0;
    if (!alt_on) begin
      nxt_d  = 1'b0;
      last_d = 1'b0;
    end else begin
      if (rd_end && pend_q)    nxt_d  = ~nxt_q;
      if (rd_start && spr_hit) last_d = nxt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      nxt_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      nxt_q  <= nxt_d;
      last_q <= last_d;
    end
  end

  assign nxt_src  = nxt_q;
  assign last_src = last_q;
endmodule

// File: rtl/fcnt_rdcap.sv
module fcnt_rdcap
  import fcnt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              unlocked,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] scratch,
  input  logic [CW-1:0]     tx_cnt,
  input  logic [CW-1:0]     rx_cnt,
  input  logic              alt_on,
  input  logic              nxt_src,
  input  logic              last_src,
  output logic              rd_start,
  output logic              rd_end,
  output logic [DATA_W-1:0] rdata
);
  logic              rd_q;
  logic [DATA_W-1:0] rdat_q, mux;
  logic              spr_src;

  assign rd_start = rd & ~rd_q;
  assign rd_end   = ~rd & rd_q;
  assign spr_src  = alt_on ? nxt_src : ctl.emode[0];

  always_comb begin
    mux = '0;
    if (addr == OFS_SPR) begin
      mux = ctl.cnt_swap ? DATA_W'(spr_src ? tx_cnt : rx_cnt) : scratch;
    end else if (unlocked && addr == OFS_TRG) begin
      mux = DATA_W'(ctl.dir_tx ? tx_cnt : rx_cnt);
      if (alt_on) mux[DATA_W-1] = last_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdat_q <= '0;
    else if (rd_start) rdat_q <= mux;
  end

  assign rdata = rdat_q;
endmodule

// File: rtl/fcnt_regblk.sv
module fcnt_regblk
  import fcnt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] lcr_val,
  input  logic [CW-1:0]     tx_count,
  input  logic [CW-1:0]     rx_count,
  output logic [DATA_W-1:0] host_rdata,
  output logic [CW-1:0]     tx_trig,
  output logic [CW-1:0]     rx_trig
);
  logic [1:0]        rst_sync;
  logic              rst_sn;
  logic              unlocked, alt_on;
  ctl_t              ctl;
  logic [DATA_W-1:0] scratch;
  logic              rd_start, rd_end, nxt_src, last_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  assign unlocked = (lcr_val == UNLOCK_CODE);
  assign alt_on   = ctl.cnt_swap & (&ctl.emode);

  fcnt_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .unlocked(unlocked), .ctl_o(ctl),
    .scratch_o(scratch), .tx_trig_o(tx_trig), .rx_trig_o(rx_trig)
  );

  fcnt_alt u_alt (
    .clk(clk), .rst_n(rst_sn), .alt_on(alt_on), .rd_start(rd_start),
    .rd_end(rd_end), .spr_hit(host_addr == OFS_SPR),
    .nxt_src(nxt_src), .last_src(last_src)
  );

  fcnt_rdcap #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_sn), .rd(host_rd), .addr(host_addr),
    .unlocked(unlocked), .ctl(ctl), .scratch(scratch),
    .tx_cnt(tx_count), .rx_cnt(rx_count), .alt_on(alt_on),
    .nxt_src(nxt_src), .last_src(last_src), .rd_start(rd_start),
    .rd_end(rd_end), .rdata(host_rdata)
  );
endmodule

// File: rtl/fcnt_regblk_chk.sv
module fcnt_regblk_chk
  import fcnt_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int MW = (CW > DATA_W) ? CW : DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] lcr_val,
  input logic [DATA_W-1:0] host_rdata,
  input logic [CW-1:0]     tx_trig,
  input logic [CW-1:0]     rx_trig
);
  logic          rd_d;
  logic [CW-1:0] exp_lvl;
  logic          trg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_d <= 1'b0;
    else        rd_d <= host_rd;
  end

  assign exp_lvl = (MW'(host_wdata) > MW'(DEPTH)) ? CW'(DEPTH) : CW'(host_wdata);
  assign trg_wr  = host_wr && lcr_val == UNLOCK_CODE && host_addr == OFS_TRG;

  p_trig_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_trig) <= DEPTH) && (int'(rx_trig) <= DEPTH));

  p_trig_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trg_wr |=> (tx_trig == $past(exp_lvl) || rx_trig == $past(exp_lvl)));

  p_trig_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trg_wr |=> ($stable(tx_trig) && $stable(rx_trig)));

  p_locked_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rd_d && lcr_val != UNLOCK_CODE && host_addr != OFS_SPR)
      |=> host_rdata == '0);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !rd_d) |=> $stable(host_rdata));
endmodule

bind fcnt_regblk fcnt_regblk_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sn), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .lcr_val(lcr_val),
  .host_rdata(host_rdata), .tx_trig(tx_trig), .rx_trig(rx_trig)
);

// File: tb/sim_fcnt_regblk.sv
`timescale 1ns/1ps
module sim_fcnt_regblk;
  localparam int DEPTH = 128;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, wr, rd;
  logic [2:0]    addr;
  logic [7:0]    wdata, lcr, rdata;
  logic [CW-1:0] txc, rxc, tx_trig, rx_trig;
  int total = 0, fails = 0;

  fcnt_regblk #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wr(wr), .host_rd(rd),
    .host_wdata(wdata), .lcr_val(lcr), .tx_count(txc), .rx_count(rxc),
    .host_rdata(rdata), .tx_trig(tx_trig), .rx_trig(rx_trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); v = rdata; rd = 1'b0;
    @(negedge clk);
  endtask

  function automatic int sat(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int exp_tx, exp_rx;
    rst_n = 1'b0; wr = 0; rd = 0; addr = 0; wdata = 0; lcr = 8'h03;
    txc = 0; rxc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 tx_trig", tx_trig, 1);
    chk("R1 rx_trig", rx_trig, 1);
    chk("R1 rdata", rdata, 0);
    bus_rd(3'd7, v); chk("R1 scratch", v, 0);

    // R3 trigger programming sweep, both directions
    lcr = 8'hBF; exp_tx = 1; exp_rx = 1;
    for (int d = 0; d < 2; d++) begin
      bus_wr(3'd1, {d[0], 7'd0});
      for (int x = 0; x < 256; x++) begin
        bus_wr(3'd0, x[7:0]);
        if (d == 1) exp_tx = sat(x); else exp_rx = sat(x);
        chk("R3 tx_trig", tx_trig, exp_tx);
        chk("R3 rx_trig", rx_trig, exp_rx);
      end
    end
    bus_wr(3'd0, 8'd40);  exp_tx = 40;   // dir still tx
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd0, 8'd20);  exp_rx = 20;
    chk("R3 tx final", tx_trig, 40);
    chk("R3 rx final", rx_trig, 20);

    // R4 count readback sweep through offset 0
    for (int d = 0; d < 2; d++) begin
      bus_wr(3'd1, {d[0], 7'd0});
      for (int c = 0; c <= DEPTH; c++) begin
        txc = (d == 1) ? CW'(c) : CW'(DEPTH - c);
        rxc = (d == 1) ? CW'(DEPTH - c) : CW'(c);
        bus_rd(3'd0, v);
        chk("R4 count", v, c);
      end
    end

    // R2 lock: every other line-control value blocks offsets 0 and 1
    bus_wr(3'd1, 8'h00);
    rxc = 5; txc = 9;
    for (int l = 0; l < 256; l++) begin
      if (l != 8'hBF) begin
        lcr = l[7:0];
        bus_wr(3'd0, 8'd77);
        chk("R2 tx_trig held", tx_trig, exp_tx);
        chk("R2 rx_trig held", rx_trig, exp_rx);
      end
    end
    lcr = 8'h03;
    bus_rd(3'd0, v); chk("R2 locked read 0", v, 0);
    bus_rd(3'd1, v); chk("R2 locked read 1", v, 0);
    bus_wr(3'd1, 8'h80);
    lcr = 8'hBF;
    bus_rd(3'd0, v); chk("R2 control write ignored", v, 5);

    // R5 plain scratch byte
    foreach (v[i]) begin end
    for (int k = 0; k < 4; k++) begin
      lcr = k[0] ? 8'hBF : 8'h03;
      bus_wr(3'd7, 8'hA5 ^ (8'd17 * k[7:0]));
      bus_rd(3'd7, v); chk("R5 scratch", v, 8'hA5 ^ (8'd17 * k[7:0]));
    end

    // R6 count window
    lcr = 8'hBF;
    bus_wr(3'd7, 8'h3C);
    bus_wr(3'd1, 8'h40);
    rxc = 20; txc = 40;
    bus_wr(3'd7, 8'h00);
    bus_rd(3'd7, v); chk("R6 rx count", v, 20);
    bus_wr(3'd7, 8'h01);
    bus_rd(3'd7, v); chk("R6 tx count", v, 40);
    lcr = 8'h03;
    bus_rd(3'd7, v); chk("R6 count any lcr", v, 40);
    bus_rd(3'd7, v); chk("R6 no alternation", v, 40);
    lcr = 8'hBF;
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd7, v); chk("R6 scratch kept", v, 8'h3C);

    // R7 / R9 alternation and direction tag
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd7, 8'h03);
    rxc = 11; txc = 99;
    bus_rd(3'd0, v); chk("R9 tag before reads", v, 11);
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'd7, v); chk("R7 alternate", v, (i % 2 == 0) ? 11 : 99);
      bus_rd(3'd0, v); chk("R9 tag", v, ((i % 2) << 7) | 11);
    end

    // R8 restart on receive
    bus_rd(3'd7, v); chk("R7 seventh read", v, 11);
    bus_wr(3'd7, 8'h01);
    bus_rd(3'd7, v); chk("R8 fixed tx", v, 99);
    bus_wr(3'd7, 8'h03);
    bus_rd(3'd0, v); chk("R8 tag cleared", v, 11);
    bus_rd(3'd7, v); chk("R8 restart rx", v, 11);
    bus_rd(3'd7, v); chk("R8 then tx", v, 99);

    // R10 capture vs count change in the same cycle
    bus_wr(3'd7, 8'h00);
    bus_wr(3'd1, 8'h00);
    rxc = 60;
    @(negedge clk); addr = 3'd0; rd = 1'b1; rxc = 62;
    @(negedge clk); rxc = 63;
    chk("R10 capture at rise", rdata, 62);
    @(negedge clk); rxc = 64;
    @(negedge clk);
    chk("R10 held during strobe", rdata, 62);
    rd = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 held after strobe", rdata, 62);
    bus_rd(3'd0, v); chk("R10 new read", v, 64);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule